// File: doc/BRIEF.md
# Pipelined Adaptive-Filter Inner Product with Error Output

This block computes the output of an N-tap FIR section for a delayed-update adaptive filter. In the same pass it computes the error between that output and a desired sample. On each accepted beat it takes N signed samples from the delay line, N signed weights and one signed desired sample. It returns the filter output `y` and the error `e = d - y`. The weight update is handled elsewhere and consumes `e` and the delayed samples.

Each sample is split into two-bit radix-4 digits. A small decoder selects w, 2w or 3w, or for the top digit w, -2w or -w, so no multiplier is needed. One adder tree per digit position sums that position's partial products across all taps. Only after that does a single shift-add combine the digit sums with weights 4^k. A register stage sits between the trees and the shift-add, and a second stage holds the outputs. The result is truncated to a parameterised number of least-significant bits. The full-width digit sums keep every carry, so the truncation error stays below one output LSB step.

Both data interfaces are valid/ready streams. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. A result is taken when `out_valid` and `out_ready` are both high. When the downstream side holds `out_ready` low, the whole pipeline freezes. The result on the outputs stays steady, and `in_ready` drops in the same cycle.

Top module: `afip_inner_product`

## Requirements
- R1: `y_out` equals the sum over all taps of sample times weight, both two's complement and tap i held in bits [8i+7:8i] of its bus. That sum is rounded toward minus infinity to a multiple of 2^TRUNC_LSB (default TRUNC_LSB = 2, so the lowest two bits read zero).
- R2: `e_out` equals the desired sample, sign-extended to the output width, minus `y_out`, taken modulo 2^Y_W.
- R3: A beat accepted at clock edge t appears with `out_valid` high after edge t+1 when `out_ready` stays high. It is not visible after edge t alone. Beats accepted on consecutive edges leave on consecutive edges in order.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `y_out` and `e_out` hold their values. No accepted beat is lost or duplicated.
- R5: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R6: While `rst_n` is low, and after it is released with no input, `out_valid` is low and `in_ready` is high. A reset during operation discards beats in flight.
- R7: Extreme operands give exact results without overflow, for example -128 times -128 on every tap (65536) or 127 times -128 on every tap (-65024).
- R8: A cycle without an accepted beat produces no result: `out_valid` stays low when nothing was accepted.
- R9: Samples are read as radix-4 digits. The lower digits are unsigned (0 to 3). The top digit, bits [7:6], is signed (-2 to 1). Every digit value at every position gives the correct product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| x_taps | input | N_TAPS*SAMP_W (32) | Delay-line samples, tap i in bits [8i+7:8i] |
| w_taps | input | N_TAPS*COEF_W (32) | Weights, tap i in bits [8i+7:8i] |
| d_in | input | SAMP_W (8) | Desired sample, two's complement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| y_out | output | Y_W (18) | Filter output, two's complement |
| e_out | output | Y_W (18) | Error d - y, two's complement |

## Verification
Some checks run on every cycle. Each digit's partial product is compared with the true product of the weight and that signed or unsigned digit value. Each per-digit tree sum is bounded. A stalled result must stay frozen. An accepted beat must reach the middle stage and then the output, and an idle middle stage must never produce an output.

Other properties need the bench's scenarios. The arithmetic value of `y` and `e` after truncation and error wrap is checked against a table of hand-computed sums. The two-cycle timing, back-to-back ordering, a beat arriving during a stall, and a reset mid-stream are checked by directed tests.

// File: rtl/afip_pkg.sv
package afip_pkg;
  // Width of one radix-4 partial product for a COEF_W-bit weight:
  // magnitudes up to 3|w| need two extra bits.
  function automatic int pp_width(input int coef_w);
    return coef_w + 2;
  endfunction

  // Width needed to hold the sum of n_terms values of width w_in.
  function automatic int sum_width(input int w_in, input int n_terms);
    return w_in + $clog2(n_terms);
  endfunction
endpackage

// File: rtl/afip_ppg.sv
// Partial-product generator for one tap: one two-bit digit decoder and
// one AND-OR select per digit. The top digit is signed.
module afip_ppg #(
  parameter int SAMP_W = 8,
  parameter int COEF_W = 8,
  parameter int PP_W   = afip_pkg::pp_width(COEF_W),
  parameter int NDIG   = SAMP_W / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SAMP_W-1:0]      x,
  input  logic [COEF_W-1:0]      w,
  output logic [NDIG*PP_W-1:0]   pp_flat
);
  logic signed [PP_W-1:0] w_ext;
  assign w_ext = {{(PP_W-COEF_W){w[COEF_W-1]}}, w};

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    localparam bit IS_TOP = (k == NDIG - 1);
    logic [1:0] dg;
    logic sel1, sel2, sel3;
    logic signed [PP_W-1:0] m1, m2, m3, pp_k;

    assign dg   = x[2*k +: 2];
    assign sel1 = ~dg[1] &  dg[0];
    assign sel2 =  dg[1] & ~dg[0];
    assign sel3 =  dg[1] &  dg[0];

    if (IS_TOP) begin : g_top
      // digit value is -2*u1 + u0: codes 01, 10, 11 map to 1, -2, -1
      assign m1 = w_ext;
      assign m2 = -(w_ext <<< 1);
      assign m3 = -w_ext;
    end else begin : g_low
      assign m1 = w_ext;
      assign m2 = w_ext <<< 1;
      assign m3 = w_ext + (w_ext <<< 1);
    end

    assign pp_k = ({PP_W{sel1}} & m1) | ({PP_W{sel2}} & m2) | ({PP_W{sel3}} & m3);
    assign pp_flat[k*PP_W +: PP_W] = pp_k;

    AST_PP_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pp_k) == int'($signed(w)) *
        (IS_TOP ? int'($signed(dg)) : int'({1'b0, dg}))) else $error("pp digit mismatch"); // R9
  end
endmodule

// File: rtl/afip_digit_tree.sv
// Sums the partial products of one digit position across every tap.
module afip_digit_tree #(
  parameter int N_TAPS = 4,
  parameter int COEF_W = 8,
  parameter int PP_W   = afip_pkg::pp_width(COEF_W),
  parameter int TREE_W = afip_pkg::sum_width(PP_W, N_TAPS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_TAPS*PP_W-1:0]      pp_col,
  output logic signed [TREE_W-1:0]    sum
);
  localparam int LIMIT = N_TAPS * 3 * (1 << (COEF_W - 1));

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_TAPS; i++) begin
      sum += {{(TREE_W-PP_W){pp_col[i*PP_W + PP_W - 1]}}, pp_col[i*PP_W +: PP_W]};
    end
  end

  AST_TREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sum) <= LIMIT) && (int'(sum) >= -LIMIT)) else $error("tree sum out of range"); // R7
endmodule

// File: rtl/afip_inner_product.sv
// Two-stage pipelined inner product with error output.
module afip_inner_product #(
  parameter int N_TAPS    = 4,
  parameter int SAMP_W    = 8,
  parameter int COEF_W    = 8,
  parameter int TRUNC_LSB = 2
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         in_valid,
  output logic                                         in_ready,
  input  logic [N_TAPS*SAMP_W-1:0]                     x_taps,
  input  logic [N_TAPS*COEF_W-1:0]                     w_taps,
  input  logic [SAMP_W-1:0]                            d_in,
  output logic                                         out_valid,
  input  logic                                         out_ready,
  output logic [SAMP_W+COEF_W+$clog2(N_TAPS)-1:0]      y_out,
  output logic [SAMP_W+COEF_W+$clog2(N_TAPS)-1:0]      e_out
);
  localparam int NDIG   = SAMP_W / 2;
  localparam int PP_W   = afip_pkg::pp_width(COEF_W);
  localparam int TREE_W = afip_pkg::sum_width(PP_W, N_TAPS);
  localparam int Y_W    = SAMP_W + COEF_W + $clog2(N_TAPS);

  logic [NDIG*PP_W-1:0]   pp_tap [N_TAPS];
  logic [N_TAPS*PP_W-1:0] pp_col [NDIG];
  logic signed [TREE_W-1:0] tree_sum [NDIG];

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    afip_ppg #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .PP_W(PP_W), .NDIG(NDIG)) u_ppg (
      .clk    (clk),
      .rst_n  (rst_n),
      .x      (x_taps[i*SAMP_W +: SAMP_W]),
      .w      (w_taps[i*COEF_W +: COEF_W]),
      .pp_flat(pp_tap[i])
    );
  end

  for (genvar k = 0; k < NDIG; k++) begin : g_col
    for (genvar i = 0; i < N_TAPS; i++) begin : g_pick
      assign pp_col[k][i*PP_W +: PP_W] = pp_tap[i][k*PP_W +: PP_W];
    end
    afip_digit_tree #(.N_TAPS(N_TAPS), .COEF_W(COEF_W), .PP_W(PP_W), .TREE_W(TREE_W)) u_tree (
      .clk   (clk),
      .rst_n (rst_n),
      .pp_col(pp_col[k]),
      .sum   (tree_sum[k])
    );
  end

  // Whole-pipeline stall: every stage moves only when the output can move.
  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  // Stage 1: per-digit sums and desired sample
  logic                      v1;
  logic signed [TREE_W-1:0]  tree_q [NDIG];
  logic [SAMP_W-1:0]         d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
    end else if (en) begin
      v1 <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      for (int k = 0; k < NDIG; k++) tree_q[k] <= tree_sum[k];
      d_q <= d_in;
    end
  end

  // Shift-add across digit positions, truncation, error
  logic signed [Y_W-1:0] y_full, y_tr, d_ext, e_c;
  always_comb begin
    y_full = '0;
    for (int k = 0; k < NDIG; k++) begin
      y_full += {{(Y_W-TREE_W){tree_q[k][TREE_W-1]}}, tree_q[k]} <<< (2*k);
    end
    y_tr  = (y_full >>> TRUNC_LSB) <<< TRUNC_LSB;
    d_ext = {{(Y_W-SAMP_W){d_q[SAMP_W-1]}}, d_q};
    e_c   = d_ext - y_tr;
  end

  // Stage 2: output registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (en) begin
      out_valid <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      y_out <= y_tr;
      e_out <= e_c;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(y_out) && $stable(e_out)) else $error("stall not held"); // R4
  AST_ACCEPT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> v1) else $error("accepted beat lost"); // R3
  AST_MID_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    v1 && in_ready |=> out_valid) else $error("beat did not reach output"); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 && in_ready |=> !out_valid) else $error("output without input"); // R8
endmodule

// File: tb/afip_inner_product_bench.sv
module afip_inner_product_bench;
  localparam int N_TAPS = 4;
  localparam int T      = 2;
  localparam int Y_W    = 18;

  typedef struct packed {
    logic [31:0]        x;
    logic [31:0]        w;
    logic [7:0]         d;
    logic signed [31:0] exact;   // hand-computed sum of products
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{32'h00000000, 32'h12345678, 8'h05, 32'sd0},
    '{32'h01010101, 32'h04030201, 8'h00, 32'sd10},
    '{32'h80808080, 32'h80808080, 8'h7F, 32'sd65536},
    '{32'h7F7F7F7F, 32'h80808080, 8'h80, -32'sd65024},
    '{32'hF905FF03, 32'h02FE0707, 8'hFD, -32'sd10},
    '{32'h0000AA55, 32'h00005555, 8'h00, -32'sd85},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 8'h01, 32'sd4},
    '{32'hFD19CE64, 32'h0DF509F9, 8'h33, -32'sd1464}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [31:0] x_taps = '0;
  logic [31:0] w_taps = '0;
  logic [7:0]  d_in = '0;
  logic in_ready, out_valid;
  logic [Y_W-1:0] y_out, e_out;

  int n_tests = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  afip_inner_product u_afip_inner_product (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x_taps(x_taps), .w_taps(w_taps), .d_in(d_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .y_out(y_out), .e_out(e_out)
  );

  function automatic int exp_y(input int exact);
    return (exact >>> T) <<< T;                       // R1 floor truncation
  endfunction

  function automatic int exp_e(input logic [7:0] d, input int y);
    int diff;
    logic signed [Y_W-1:0] wrapped;
    diff = int'($signed(d)) - y;
    wrapped = diff[Y_W-1:0];                          // R2 modulo 2^Y_W
    return int'(wrapped);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic drive(input vec_t v);
    x_taps = v.x; w_taps = v.w; d_in = v.d; in_valid = 1'b1;
  endtask

  task automatic check_out(input vec_t v, input string tag);
    chk({tag, " out_valid"}, int'(out_valid), 1);
    chk({tag, " R1 y"}, int'($signed(y_out)), exp_y(v.exact));
    chk({tag, " R2 e"}, int'($signed(e_out)), exp_e(v.d, exp_y(v.exact)));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R6: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 out_valid in reset", int'(out_valid), 0);
    chk("R6 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R6 out_valid idle after reset", int'(out_valid), 0);

    // Table: R1 R2 R7 R9, with R3 latency
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); drive(TBL[i]);
      @(posedge clk); @(negedge clk); in_valid = 1'b0;
      chk("R3 not yet valid after one edge", int'(out_valid), 0);
      @(posedge clk); @(negedge clk);
      check_out(TBL[i], "R3 R7 R9 table");
    end

    // R3: back-to-back beats leave on consecutive edges
    @(negedge clk); drive(TBL[4]);
    @(posedge clk); @(negedge clk); drive(TBL[7]);
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    check_out(TBL[4], "R3 first of pair");
    @(posedge clk); @(negedge clk);
    check_out(TBL[7], "R3 second of pair");

    // R8: idle cycles produce nothing
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 no output when idle", int'(out_valid), 0);
    end

    // R4 R5: back-pressure
    @(negedge clk); out_ready = 1'b0; drive(TBL[1]);
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check_out(TBL[1], "R4 stalled result");
    chk("R5 in_ready low while stalled", int'(in_ready), 0);
    drive(TBL[6]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out(TBL[1], "R4 held over stall");
    chk("R5 in_ready still low", int'(in_ready), 0);
    out_ready = 1'b1;
    #1 chk("R5 in_ready follows out_ready", int'(in_ready), 1);
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    chk("R4 stalled result consumed once", int'(out_valid), 0);
    @(posedge clk); @(negedge clk);
    check_out(TBL[6], "R4 beat offered during stall");

    // R6: reset mid-stream discards the beat in flight
    @(negedge clk); drive(TBL[7]);
    @(posedge clk); @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 flush on reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R6 nothing after reset release", int'(out_valid), 0);

    finish_run();
  end
endmodule